// File: doc/BRIEF.md
# Timestamp-Triggered Event Queue

This block keeps a free-running 64-bit sample timestamp and a first-in first-out list of scheduled events. The host writes an event as a target timestamp plus a tag. The block watches only the oldest pending event. Once the running timestamp has reached that event's target, the block raises an interrupt and shows the event's tag. The interrupt stays up until the host acknowledges it. The acknowledge removes the event, and the next one is then compared.

A target that already lies in the past fires at once. A reserved all-ones target fires as soon as its entry becomes the oldest, whatever the count is. Two inputs empty the list: one is the host's cancel request and the other is the open/close flush. Neither leaves anything behind that could fire later. What the event does when it fires is left to the logic that consumes the interrupt.

Top module: `ts_event_sched`

## Requirements
- R1: After synchronous reset, `irq` and `push_err` are 0, `ts_count` is 0 and no entry is pending.
- R2: `ts_count` rises by exactly one on each clock edge where `sample_en` is 1 and holds its value otherwise.
- R3: `irq` rises on the first clock edge at which the head entry is valid and the value of `ts_count` before that edge is at least the head's target, using an unsigned 64-bit comparison. `irq_tag` then holds the head's tag.
- R4: An entry whose target is already at or below `ts_count` raises `irq` on the second edge after the push that queued it into an empty list.
- R5: A target of all ones (0xFFFF_FFFF_FFFF_FFFF) means "now" and fires on the edge after the entry becomes head, whatever `ts_count` is.
- R6: Entries fire in the order they were pushed.
- R7: Once raised, `irq` and `irq_tag` hold until an edge that sees `irq_ack`=1. That edge clears `irq` and removes the head, and the next head can raise `irq` no sooner than the following edge. An `irq_ack` pulse while `irq` is 0 removes nothing.
- R8: Up to 16 entries can be pending. A push while 16 are pending is dropped, and `push_err` is 1 for the following cycle. This holds even when the same edge pops an entry. `push_err` is 0 after any other cycle.
- R9: `cancel_all` or `flush` at an edge removes every pending entry and clears `irq`. Removed entries never fire, and pushes made afterwards work normally. A push in the same cycle as a clear is dropped without an error.
- R10: Targets with bit 63 set are not treated as negative: such a target stays pending while `ts_count` is small.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Advance the timestamp by one |
| push_valid | input | 1 | Queue a new event this cycle |
| push_time | input | 64 | Target timestamp of the new event (all ones = now) |
| push_tag | input | TAG_W | Tag of the new event |
| cancel_all | input | 1 | Host request to drop every pending event |
| flush | input | 1 | Open/close flush; drops every pending event |
| irq_ack | input | 1 | Acknowledge the raised event and remove it |
| irq | output | 1 | Event due; held until acknowledged |
| irq_tag | output | TAG_W | Tag of the raised event |
| push_err | output | 1 | Previous push was rejected because the queue was full |
| ts_count | output | 64 | Running sample timestamp |

## Verification
The case of interest is an acknowledge that pops the head in the same cycle as a push arrives at a full queue. The push decision has to use the occupancy from before the edge. The bench fills all 16 slots with past-due events and lets the first one fire. It then drives `irq_ack` and a tagged `push_valid` together. It expects `push_err` the next cycle, followed by exactly fifteen further interrupts carrying tags 1 to 15. Neither the dropped tags nor any extra interrupt may appear. A cancel issued while an interrupt is raised is also checked: `irq` must fall and must stay low.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int TS_W = 64;
  typedef logic [TS_W-1:0] ts_t;
  localparam ts_t TS_NOW = '1;
  typedef enum logic {EV_WAIT = 1'b0, EV_RAISED = 1'b1} ev_state_t;
endpackage

// File: rtl/evq_tscount.sv
module evq_tscount
  import evq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output ts_t  count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (adv) count <= count + ts_t'(1);
  end

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    adv |=> (count == $past(count) + ts_t'(1)));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(count));
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 72
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          wr_ok, rd_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign wr_ok   = wr_en && !full && !clr;
  assign rd_ok   = rd_en && !empty && !clr;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (rd_ok) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full || $past(clr));
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/evq_fire.sv
module evq_fire
  import evq_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             head_valid,
  input  ts_t              head_time,
  input  logic [TAG_W-1:0] head_tag,
  input  ts_t              now_count,
  input  logic             ack,
  output logic             irq,
  output logic [TAG_W-1:0] irq_tag,
  output logic             pop
);
  ev_state_t state;
  logic      due;

  assign due = head_valid && ((head_time == TS_NOW) || (now_count >= head_time));
  assign pop = (state == EV_RAISED) && ack && !clr;
  assign irq = (state == EV_RAISED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= EV_WAIT;
      irq_tag <= '0;
    end else if (clr) begin
      state   <= EV_WAIT;
    end else begin
      case (state)
        EV_WAIT: if (due) begin
          state   <= EV_RAISED;
          irq_tag <= head_tag;
        end
        EV_RAISED: if (ack) state <= EV_WAIT;
        default: state <= EV_WAIT;
      endcase
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack && !clr) |=> (irq && $stable(irq_tag)));
  a_r7_gap: assert property (@(posedge clk) disable iff (rst)
    (irq && ack) |=> !irq);
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clr |=> !irq);
  a_r3_needs_head: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(head_valid));
endmodule

// File: rtl/ts_event_sched.sv
module ts_event_sched
  import evq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_en,
  input  logic             push_valid,
  input  logic [63:0]      push_time,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             cancel_all,
  input  logic             flush,
  input  logic             irq_ack,
  output logic             irq,
  output logic [TAG_W-1:0] irq_tag,
  output logic             push_err,
  output logic [63:0]      ts_count
);
  localparam int EW = TS_W + TAG_W;

  logic          clr;
  logic [EW-1:0] head;
  logic          q_empty, q_full, pop;

  assign clr = cancel_all || flush;

  evq_tscount u_cnt (
    .clk   (clk),
    .rst   (rst),
    .adv   (sample_en),
    .count (ts_count)
  );

  evq_fifo #(.DEPTH(DEPTH), .W(EW)) u_q (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .wr_en   (push_valid),
    .wr_data ({push_time, push_tag}),
    .rd_en   (pop),
    .rd_data (head),
    .empty   (q_empty),
    .full    (q_full)
  );

  evq_fire #(.TAG_W(TAG_W)) u_fire (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .head_valid (!q_empty),
    .head_time  (head[EW-1:TAG_W]),
    .head_tag   (head[TAG_W-1:0]),
    .now_count  (ts_count),
    .ack        (irq_ack),
    .irq        (irq),
    .irq_tag    (irq_tag),
    .pop        (pop)
  );

  always_ff @(posedge clk) begin
    if (rst) push_err <= 1'b0;
    else     push_err <= push_valid && q_full && !clr;
  end

  a_r8_err_on_full: assert property (@(posedge clk) disable iff (rst)
    (push_valid && q_full && !clr) |=> push_err);
  a_r8_err_only_full: assert property (@(posedge clk) disable iff (rst)
    !(push_valid && q_full) |=> !push_err);
endmodule

// File: tb/ts_event_sched_tb.sv
module ts_event_sched_tb;
  localparam int TAG_W = 8;
  localparam logic [63:0] NOW = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 0, rst = 1, sample_en = 0, push_valid = 0;
  logic [63:0] push_time = '0;
  logic [TAG_W-1:0] push_tag = '0;
  logic cancel_all = 0, flush = 0, irq_ack = 0;
  logic irq, push_err;
  logic [TAG_W-1:0] irq_tag;
  logic [63:0] ts_count;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ts_event_sched #(.DEPTH(16), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .push_valid(push_valid),
    .push_time(push_time), .push_tag(push_tag), .cancel_all(cancel_all),
    .flush(flush), .irq_ack(irq_ack), .irq(irq), .irq_tag(irq_tag),
    .push_err(push_err), .ts_count(ts_count)
  );

  // Vector table, walked with ts_count parked at 100: target, tag, fires now?
  localparam logic [63:0] V_TGT [6] = '{64'd50, 64'd100, 64'd101, NOW,
                                        64'h8000_0000_0000_0000, 64'd0};
  localparam logic [7:0]  V_TAG [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
  localparam logic        V_EXP [6] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam string       V_REQ [6] = '{"R4", "R3", "R3", "R5", "R10", "R4"};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] t, input logic [7:0] g);
    push_valid = 1; push_time = t; push_tag = g;
    tick();
    push_valid = 0;
  endtask

  task automatic ack();
    irq_ack = 1; tick(); irq_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    chk("R1 irq", irq, 0);
    chk("R1 push_err", push_err, 0);
    chk("R1 count", ts_count, 0);

    sample_en = 1; repeat (100) tick(); sample_en = 0;
    chk("R2 advance", ts_count, 100);
    tick(); tick();
    chk("R2 hold", ts_count, 100);

    for (int i = 0; i < 6; i++) begin
      push(V_TGT[i], V_TAG[i]);
      tick();
      chk(V_REQ[i], irq, V_EXP[i]);
      if (V_EXP[i]) begin
        chk(V_REQ[i], irq_tag, V_TAG[i]);
        ack();
        chk("R7 cleared", irq, 0);
      end else begin
        cancel_all = 1; tick(); cancel_all = 0;
      end
      tick();
    end

    // R3: exact edge of a future target
    push(64'd110, 8'h70);
    sample_en = 1;
    for (int k = 0; k < 20; k++) begin
      logic [63:0] c;
      c = ts_count;
      tick();
      chk("R3 edge", irq, (c >= 64'd110));
      if (irq) break;
    end
    sample_en = 0;
    chk("R3 tag", irq_tag, 8'h70);
    ack(); tick();

    // R7: stray ack is ignored, then hold until ack
    push(64'd125, 8'h05);
    irq_ack = 1; tick(); tick(); irq_ack = 0;
    chk("R7 stray ack", irq, 0);
    sample_en = 1; repeat (16) tick(); sample_en = 0;
    tick();
    chk("R7 survived stray ack", irq, 1);
    chk("R7 tag", irq_tag, 8'h05);
    repeat (3) tick();
    chk("R7 hold", irq, 1);
    chk("R7 hold tag", irq_tag, 8'h05);
    ack(); tick();

    // R6: order
    push(64'd0, 8'h01); push(NOW, 8'h02); push(64'd3, 8'h03);
    for (int j = 1; j <= 3; j++) begin
      chk("R6 fire", irq, 1);
      chk("R6 order", irq_tag, 8'(j));
      ack();
      chk("R7 gap", irq, 0);
      tick();
    end
    chk("R6 drained", irq, 0);

    // R8: full queue, push rejected also on a popping edge
    for (int j = 0; j < 16; j++) push(64'd0, 8'(j));
    chk("R8 no err while filling", push_err, 0);
    push(64'd0, 8'h99);
    chk("R8 reject", push_err, 1);
    chk("R8 head", irq_tag, 8'h00);
    irq_ack = 1; push_valid = 1; push_time = 64'd0; push_tag = 8'h77;
    tick();
    irq_ack = 0; push_valid = 0;
    chk("R8 reject with pop", push_err, 1);
    tick();
    chk("R8 err clears", push_err, 0);
    for (int j = 1; j < 16; j++) begin
      chk("R8 drain fire", irq, 1);
      chk("R8 drain tag", irq_tag, 8'(j));
      ack(); tick();
    end
    chk("R8 nothing extra", irq, 0);

    // R9: cancel and flush
    push(64'd0, 8'hA1); push(64'd0, 8'hA2); push(64'd0, 8'hA3);
    chk("R9 fired before cancel", irq, 1);
    cancel_all = 1; tick(); cancel_all = 0;
    chk("R9 cancel drops irq", irq, 0);
    repeat (3) tick();
    chk("R9 cancel stays empty", irq, 0);
    push(64'd0, 8'hB1); push(64'd0, 8'hB2);
    flush = 1; tick(); flush = 0;
    repeat (3) tick();
    chk("R9 flush empties", irq, 0);
    push(64'd0, 8'hC1);
    tick();
    chk("R9 works after flush", irq, 1);
    chk("R9 tag after flush", irq_tag, 8'hC1);
    ack(); tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule